// File: doc/BRIEF.md
# Synchronous SRAM with Selectable Output Pipeline

This block is a single-port synchronous static memory. On each rising clock edge it captures the address, write data, three chip enables and the write controls. A static mode input chooses how read data reaches the output. In flow-through mode the array output goes straight to the bus in the cycle after the read is captured. In pipelined mode the data passes through one more output register, so it appears one edge later. The output drive follows the same pipeline as read data. When a deselect (or a write) is captured, the bus therefore stays driven for the same number of edges as a read would take, and only then releases.

Writes take byte-lane selects qualified by a byte-write enable. A global write stores every lane whatever the byte controls say. The bus is modelled as a data word plus a valid flag. An asynchronous output enable and an asynchronous sleep input both clear the valid flag at once. Sleep also freezes every internal register and the array, so the stored contents and any command already in flight are kept until sleep drops. Burst address sequencing belongs to a neighbouring block and is not part of this one. A new address can be presented on every clock.

Top module: `ssr_sync_sram`

## Requirements
- R1: With `pipe_sel` high, a read captured on edge n presents `rvalid`=1 and the addressed word on `rdata` from edge n+1 until edge n+2.
- R2: With `pipe_sel` low, a read captured on edge n presents `rvalid`=1 and the addressed word from edge n until edge n+1.
- R3: After a deselect or write is captured on edge n, `rvalid` falls after edge n+1 in pipelined mode and after edge n in flow-through mode. Releasing the bus takes exactly as long as presenting read data.
- R4: With `gw_n` high and `bwe_n` low, only the lanes whose `bsel_n` bit is 0 are written. Lane k is `wdata[9k+8:9k]`. All other lanes keep their contents.
- R5: With `gw_n` low, all lanes are written, whatever `bwe_n` and `bsel_n` hold.
- R6: With `gw_n` high, a selected cycle is a read when `bwe_n` is high or when every `bsel_n` bit is 1. No lane is written in that cycle.
- R7: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect: it writes nothing and drives no data.
- R8: `oe_n` high forces `rvalid` low at once, with no clock edge needed.
- R9: `sleep` high forces `rvalid` low at once. While `sleep` is high, edges accept no command and write nothing. The array and the pipeline hold their state, so a word being presented when sleep began is presented again after sleep ends.
- R10: Commands may be issued on consecutive edges without stalls. A read captured on the edge after a write to the same address returns the newly written word.
- R11: After reset, and whenever `rvalid` is 0, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_sel | input | 1 | 1 = pipelined output path, 0 = flow-through; held static |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep / freeze, active high |
| rdata | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid | output | 1 | Bus-driven flag |

## Verification
The clocked properties assume that `pipe_sel` stays constant for two edges before a check applies. They also require `sleep` to be low on every edge in the window being checked, because sleep stretches the pipeline. The stimulus changes `pipe_sel` only between scenarios, after the bus has gone idle. It asserts `sleep`, `oe_n` and all command inputs only at the falling clock edge. The property model treats a cycle as a read from the raw enables and write controls, so the stimulus covers every chip-enable combination and each write-control mix.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } ssr_op_e;
endpackage

// File: rtl/ssr_cmd_stage.sv
module ssr_cmd_stage
   import ssr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bsel_n,
   input  logic [ADDR_W-1:0] adr,
   input  logic [DW-1:0]     wdata,
   output ssr_op_e           op_q,
   output logic [ADDR_W-1:0] adr_q,
   output logic [DW-1:0]     wdat_q,
   output logic [LANES-1:0]  mask_q
);
   logic             selected;
   logic [LANES-1:0] lane_req;
   ssr_op_e          op_nxt;

   always_comb begin
      selected = !ce1_n && ce2 && !ce3_n;
      if (!gw_n)
         lane_req = '1;
      else if (!bwe_n)
         lane_req = ~bsel_n;
      else
         lane_req = '0;
      if (!selected)
         op_nxt = OP_IDLE;
      else if (|lane_req)
         op_nxt = OP_WRITE;
      else
         op_nxt = OP_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         adr_q  <= '0;
         wdat_q <= '0;
         mask_q <= '0;
      end else if (!hold) begin
         op_q   <= op_nxt;
         adr_q  <= adr;
         wdat_q <= wdata;
         mask_q <= lane_req;
      end
   end
endmodule

// File: rtl/ssr_array.sv
module ssr_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] adr,
   input  logic [DW-1:0]     wdat,
   input  logic [LANES-1:0]  mask,
   output logic [DW-1:0]     rdat
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && mask[g])
            store[adr] <= wdat[g*LANE_W +: LANE_W];
      end

      assign rdat[g*LANE_W +: LANE_W] = store[adr];
   end
endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage #(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          pipe_sel,
   input  logic          oe_n,
   input  logic          rd_now,
   input  logic [DW-1:0] arr_dat,
   output logic [DW-1:0] dout,
   output logic          dvalid
);
   logic          drive_q;
   logic [DW-1:0] data_q;
   logic          drive_sel;
   logic [DW-1:0] data_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
         data_q  <= '0;
      end else if (!hold) begin
         drive_q <= rd_now;
         if (rd_now)
            data_q <= arr_dat;
      end
   end

   always_comb begin
      drive_sel = pipe_sel ? drive_q : rd_now;
      data_sel  = pipe_sel ? data_q  : arr_dat;
      dvalid    = drive_sel && !oe_n && !hold;
      dout      = dvalid ? data_sel : '0;
   end
endmodule

// File: rtl/ssr_sync_sram.sv
module ssr_sync_sram
   import ssr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pipe_sel,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic [ADDR_W-1:0] adr,
   input  logic              gw_n,
   input  logic              bwe_n,
   input  logic [LANES-1:0]  bsel_n,
   input  logic [DW-1:0]     wdata,
   input  logic              oe_n,
   input  logic              sleep,
   output logic [DW-1:0]     rdata,
   output logic              rvalid
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ssr_sync_sram: ADDR_W must lie in 1..12");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("ssr_sync_sram: LANES and LANE_W must be positive");
   end

   ssr_op_e           op_q;
   logic [ADDR_W-1:0] adr_q;
   logic [DW-1:0]     wdat_q;
   logic [LANES-1:0]  mask_q;
   logic [DW-1:0]     arr_dat;
   logic              wr_en;
   logic              rd_now;

   ssr_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .hold(sleep),
      .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
      .adr(adr), .wdata(wdata),
      .op_q(op_q), .adr_q(adr_q), .wdat_q(wdat_q), .mask_q(mask_q)
   );

   assign wr_en  = (op_q == OP_WRITE) && !sleep;
   assign rd_now = (op_q == OP_READ);

   ssr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .wr_en(wr_en), .adr(adr_q), .wdat(wdat_q),
      .mask(mask_q), .rdat(arr_dat)
   );

   ssr_out_stage #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n), .hold(sleep), .pipe_sel(pipe_sel),
      .oe_n(oe_n), .rd_now(rd_now), .arr_dat(arr_dat),
      .dout(rdata), .dvalid(rvalid)
   );
endmodule

// File: rtl/ssr_sync_sram_chk.sv
module ssr_sync_sram_chk #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DW    = LANES * LANE_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pipe_sel,
   input logic             ce1_n,
   input logic             ce2,
   input logic             ce3_n,
   input logic             gw_n,
   input logic             bwe_n,
   input logic [LANES-1:0] bsel_n,
   input logic             oe_n,
   input logic             sleep,
   input logic [DW-1:0]    rdata,
   input logic             rvalid
);
   logic       rd_cmd;
   logic [1:0] age;

   assign rd_cmd = !ce1_n && ce2 && !ce3_n && gw_n && (bwe_n || (&bsel_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age <= 2'd0;
      else if (age != 2'd3)
         age <= age + 2'd1;
   end

   AST_PIPE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && pipe_sel && $past(pipe_sel) && !oe_n && !sleep
       && $past(!sleep) && $past(!sleep, 2) && $past(rd_cmd, 2)) |-> rvalid); // R1

   AST_FLOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && !pipe_sel && !oe_n && !sleep && $past(!sleep)
       && $past(rd_cmd)) |-> rvalid); // R2

   AST_PIPE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && pipe_sel && $past(pipe_sel) && !sleep
       && $past(!sleep) && $past(!sleep, 2) && !$past(rd_cmd, 2)) |-> !rvalid); // R3

   AST_FLOW_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && !pipe_sel && !sleep && $past(!sleep)
       && !$past(rd_cmd)) |-> !rvalid); // R3

   AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rvalid); // R8

   AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rvalid); // R9

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rvalid |-> (rdata == '0)); // R11
endmodule

bind ssr_sync_sram ssr_sync_sram_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel),
   .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
   .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
   .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
);

// File: tb/ssr_sync_sram_bench.sv
module ssr_sync_sram_bench;
   localparam int AW = 8;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pipe_sel = 1'b1;
   logic          ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
   logic [AW-1:0] adr = '0;
   logic          gw_n = 1'b1, bwe_n = 1'b1;
   logic [NL-1:0] bsel_n = '1;
   logic [DW-1:0] wdata = '0;
   logic          oe_n = 1'b0, sleep = 1'b0;
   logic [DW-1:0] rdata;
   logic          rvalid;

   int n_chk = 0;
   int n_err = 0;
   logic [DW-1:0] model [256];

   always #5 clk = ~clk;

   ssr_sync_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_ssr_sync_sram (
      .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel),
      .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adr(adr),
      .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .wdata(wdata),
      .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .rvalid(rvalid)
   );

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      ce1_n = 1'b1; ce2 = 1'b1; ce3_n = 1'b0;
      gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
   endtask

   task automatic go_read(input logic [AW-1:0] a);
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
      gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1; adr = a;
   endtask

   // global write for lanes == '1 and gw, else byte write
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit global, input logic [NL-1:0] lanes);
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; adr = a; wdata = d;
      if (global) begin
         gw_n = 1'b0; bwe_n = 1'b1; bsel_n = '1;
         model[a] = d;
      end else begin
         gw_n = 1'b1; bwe_n = 1'b0; bsel_n = ~lanes;
         for (int k = 0; k < NL; k++)
            if (lanes[k]) model[a][k*LW +: LW] = d[k*LW +: LW];
      end
      @(negedge clk);
      go_idle();
   endtask

   // issue read, check data at mode latency, then check release one edge later
   task automatic rd_chk(input logic [AW-1:0] a, input string req);
      go_read(a);
      @(negedge clk);
      go_idle();
      if (pipe_sel) @(negedge clk);
      check(rvalid === 1'b1, req, {35'd0, rvalid}, 36'd1);
      check(rdata === model[a], req, rdata, model[a]);
      @(negedge clk);
      check(rvalid === 1'b0, "R3", {35'd0, rvalid}, 36'd0);
   endtask

   task automatic t_reset();
      check(rvalid === 1'b0, "R11", {35'd0, rvalid}, 36'd0);
      check(rdata === '0, "R11", rdata, '0);
   endtask

   task automatic t_pipe_basic();
      pipe_sel = 1'b1;
      wr(8'h10, 36'h1_2345_6789, 1'b1, '1);
      wr(8'h11, 36'hA_BCDE_F012, 1'b1, '1);
      wr(8'hFF, 36'hF_0F0F_0F0F, 1'b1, '1);
      rd_chk(8'h10, "R1");
      rd_chk(8'h11, "R1");
      rd_chk(8'hFF, "R1");
   endtask

   task automatic t_flow();
      pipe_sel = 1'b0;
      @(negedge clk);
      rd_chk(8'h10, "R2");
      rd_chk(8'hFF, "R2");
      wr(8'h20, 36'h5_5555_AAAA, 1'b1, '1);
      rd_chk(8'h20, "R10");
      pipe_sel = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_bytes();
      wr(8'h30, 36'h1_1111_1111, 1'b1, '1);
      wr(8'h30, 36'hE_EEEE_EEEE, 1'b0, 4'b0101);
      rd_chk(8'h30, "R4");
      wr(8'h31, 36'h0_0000_0000, 1'b1, '1);
      wr(8'h31, 36'h9_8765_4321, 1'b0, 4'b1000);
      rd_chk(8'h31, "R4");
      // global write overrides byte controls that select nothing
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; adr = 8'h32;
      wdata = 36'h7_7777_7777; gw_n = 1'b0; bwe_n = 1'b0; bsel_n = '1;
      model[8'h32] = 36'h7_7777_7777;
      @(negedge clk);
      go_idle();
      rd_chk(8'h32, "R5");
      // bwe_n low with no lane selected acts as a read
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; adr = 8'h30;
      wdata = 36'h0_0000_0000; gw_n = 1'b1; bwe_n = 1'b0; bsel_n = '1;
      @(negedge clk);
      go_idle();
      @(negedge clk);
      check(rvalid === 1'b1, "R6", {35'd0, rvalid}, 36'd1);
      check(rdata === model[8'h30], "R6", rdata, model[8'h30]);
      @(negedge clk);
      rd_chk(8'h30, "R6");
   endtask

   task automatic t_chipsel();
      for (int c = 0; c < 3; c++) begin
         ce1_n = (c == 0); ce2 = (c != 1); ce3_n = (c == 2);
         adr = 8'h10; wdata = 36'h0_DEAD_BEEF; gw_n = 1'b0; bwe_n = 1'b1; bsel_n = '1;
         @(negedge clk);
         gw_n = 1'b1;
         @(negedge clk);
         @(negedge clk);
         check(rvalid === 1'b0, "R7", {35'd0, rvalid}, 36'd0);
         go_idle();
      end
      rd_chk(8'h10, "R7");
   endtask

   task automatic t_oe();
      go_read(8'h11);
      @(negedge clk);
      go_idle();
      @(negedge clk);
      oe_n = 1'b1;
      #1;
      check(rvalid === 1'b0, "R8", {35'd0, rvalid}, 36'd0);
      oe_n = 1'b0;
      #1;
      check(rvalid === 1'b1, "R8", {35'd0, rvalid}, 36'd1);
      @(negedge clk);
   endtask

   task automatic t_sleep();
      go_read(8'h11);
      @(negedge clk);
      go_idle();
      @(negedge clk);
      sleep = 1'b1;
      #1;
      check(rvalid === 1'b0, "R9", {35'd0, rvalid}, 36'd0);
      wr(8'h11, 36'h0_0000_0BAD, 1'b1, '1);
      model[8'h11] = 36'hA_BCDE_F012;
      @(negedge clk);
      sleep = 1'b0;
      #1;
      check(rvalid === 1'b1, "R9", {35'd0, rvalid}, 36'd1);
      check(rdata === 36'hA_BCDE_F012, "R9", rdata, 36'hA_BCDE_F012);
      @(negedge clk);
      @(negedge clk);
      rd_chk(8'h11, "R9");
   endtask

   task automatic t_back2back();
      logic [AW-1:0] seq [4];
      seq[0] = 8'h10; seq[1] = 8'h30; seq[2] = 8'hFF; seq[3] = 8'h31;
      for (int i = 0; i < 6; i++) begin
         if (i < 4) go_read(seq[i]); else go_idle();
         @(negedge clk);
         if (i >= 1 && i <= 4) begin
            check(rvalid === 1'b1, "R10", {35'd0, rvalid}, 36'd1);
            check(rdata === model[seq[i-1]], "R10", rdata, model[seq[i-1]]);
         end
         if (i == 5) check(rvalid === 1'b0, "R3", {35'd0, rvalid}, 36'd0);
      end
      wr(8'h40, 36'h3_3C3C_3C3C, 1'b1, '1);
      rd_chk(8'h40, "R10");
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      go_idle();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pipe_basic();
      t_flow();
      t_bytes();
      t_chipsel();
      t_oe();
      t_sleep();
      t_back2back();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule